// File: doc/BRIEF.md
# Filtered Synchronous Reset Generator

This block accepts an active-low reset from a device pin and produces an active-high reset for one clock domain. The pin is not assumed to be related to the clock. It first crosses into the domain through a chain of flip-flops that carry no reset. A qualification filter then passes a reset on only after the synchronized pin has been active on `QUAL_CYCLES` consecutive clock edges. Shorter activity is treated as noise or contact bounce and is dropped. The filtered result is registered once more, so downstream logic sees a reset that changes only on the rising clock edge.

Use one instance in every clock domain. When a domain runs from a PLL output, connect the lock indication to `clk_locked_i`. While lock is low, the output reset is held asserted and the filter history is cleared. Release therefore waits for a stable clock, and a fresh qualification is needed before any later pin reset is passed on. A parameter selects how the filter is built: a saturating run counter or a shift register of past samples. Both builds give the same behaviour at the ports.

Top module: `flt_rst_gen`

## Requirements
- R1: With pin activity that qualifies, `rst_o` first reads high after rising edge number SYNC_STAGES+QUAL_CYCLES+1, counting as edge 1 the first rising edge at which `pin_rst_n_i` is low. The defaults give edge 7.
- R2: `rst_o` changes only on a rising edge of `clk_i`. A change on `pin_rst_n_i` between edges leaves `rst_o` unchanged until the next edge.
- R3: A low pulse on `pin_rst_n_i` that covers fewer than QUAL_CYCLES rising edges, including a pulse that covers no edge at all, never raises `rst_o`.
- R4: A low pulse covering P >= QUAL_CYCLES rising edges produces exactly one `rst_o` pulse, lasting P-QUAL_CYCLES+1 cycles.
- R5: Once `rst_o` is high, it stays high without a gap for as long as the synchronized pin remains low.
- R6: After the pin returns high, `rst_o` first reads low after rising edge number SYNC_STAGES+2, counting as edge 1 the first rising edge at which the pin is high.
- R7: While `clk_locked_i` is low, `rst_o` reads high from the first rising edge onward, whatever the pin does.
- R8: On the first rising edge at which `clk_locked_i` is high, `rst_o` goes low, and the filter starts over from an empty history.
- R9: An inactive sample breaks the run. Two low pulses of QUAL_CYCLES-1 edges each, separated by one high edge, never raise `rst_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock of the destination domain |
| clk_locked_i | input | 1 | High once the clock is stable. Low acts as the block's synchronous active-low reset and forces `rst_o` high |
| pin_rst_n_i | input | 1 | Asynchronous active-low reset from the pin |
| rst_o | output | 1 | Active-high reset, synchronous to `clk_i` |

## Verification
On every cycle, the assertions check four things. The filter output can rise only after a full run of QUAL_CYCLES active samples. It holds while the synchronized input stays active. It drops on the first inactive sample. The output register is forced by lock and released one edge after lock rises. Other behaviour is visible only at the ports over whole scenarios, so the bench scenarios cover it: the exact edge counts for assertion and release through the synchronizer, the exact pulse width, rejection of glitches that cover no edge, and rejection of broken runs.

// File: rtl/flt_rst_pkg.sv
// Package: shared types and helpers for the filtered reset generator.
// Assumes: nothing beyond IEEE 1800-2017.
package flt_rst_pkg;

    // Selects how the qualification filter remembers past samples.
    typedef enum logic {
        FILT_RUN_COUNT = 1'b0,  // saturating count of consecutive active samples
        FILT_HISTORY   = 1'b1   // shift register holding the last samples
    } filt_kind_e;

    // Width needed to hold values 0..max_val, never below one bit.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        int unsigned w;
        w = 1;
        while ((1 << w) <= max_val) begin
            w++;
        end
        return w;
    endfunction

endpackage

// File: rtl/flt_rst_sync_chain.sv
// Module: flt_rst_sync_chain
// Carries the asynchronous pin level into the clk_i domain through STAGES
// flip-flops in series. On purpose these flops have no reset: after power-up
// they clear themselves within STAGES edges, and a reset on them would
// bring back the removal hazard they exist to avoid.
// Assumes: STAGES >= 2. The output is converted to active-high.
module flt_rst_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic pin_rst_n_i,
    output logic active_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] stage_q;

    // Shift the raw pin level through the synchronizer stages.
    always_ff @(posedge clk_i) begin
        stage_q <= {stage_q[LAST-1:0], pin_rst_n_i};
    end

    assign active_o = ~stage_q[LAST];

    initial begin
        assert (STAGES >= 2) else $error("sync chain needs at least two stages");
    end

endmodule

// File: rtl/flt_rst_qualifier.sv
// Module: flt_rst_qualifier
// Raises qual_o only when the synchronized reset has been active on
// QUAL_CYCLES consecutive edges. It keeps qual_o high while the reset stays
// active and drops it on the first inactive sample. KIND selects either a
// saturating run counter or a shift register of past samples.
// Assumes: QUAL_CYCLES >= 1. locked_i low is a synchronous active-low reset.
module flt_rst_qualifier
    import flt_rst_pkg::*;
#(
    parameter int unsigned QUAL_CYCLES = 4,
    parameter filt_kind_e  KIND        = FILT_RUN_COUNT
) (
    input  logic clk_i,
    input  logic locked_i,
    input  logic active_i,
    output logic qual_o
);

    localparam int unsigned RUN_W = cnt_width(QUAL_CYCLES);
    localparam int unsigned CHK_W = cnt_width(QUAL_CYCLES);

    logic qual_q;

    generate
        if (KIND == FILT_RUN_COUNT) begin : g_count
            localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(QUAL_CYCLES - 1);
            logic [RUN_W-1:0] run_q;

            // Count consecutive active samples; qualify once the run is full.
            always_ff @(posedge clk_i) begin
                if (!locked_i) begin
                    run_q  <= '0;
                    qual_q <= 1'b0;
                end else if (active_i) begin
                    if (run_q != RUN_TOP) begin
                        run_q <= run_q + 1'b1;
                    end
                    qual_q <= (run_q == RUN_TOP);
                end else begin
                    run_q  <= '0;
                    qual_q <= 1'b0;
                end
            end
        end else if (QUAL_CYCLES == 1) begin : g_hist_one
            // With a one-cycle window the current sample decides alone.
            always_ff @(posedge clk_i) begin
                if (!locked_i) begin
                    qual_q <= 1'b0;
                end else begin
                    qual_q <= active_i;
                end
            end
        end else begin : g_hist
            localparam int unsigned HW = QUAL_CYCLES - 1;
            logic [HW-1:0] hist_q;

            // Keep the last HW samples; qualify when all of them and the current one are active.
            always_ff @(posedge clk_i) begin
                if (!locked_i) begin
                    hist_q <= '0;
                    qual_q <= 1'b0;
                end else begin
                    hist_q <= (hist_q << 1) | HW'(active_i);
                    qual_q <= active_i & (&hist_q);
                end
            end
        end
    endgenerate

    assign qual_o = qual_q;

    // Checker: an independent saturating run length of active samples.
    logic [CHK_W-1:0] chk_run_q;

    // Track the observed run of active samples for the assertions.
    always_ff @(posedge clk_i) begin
        if (!locked_i) begin
            chk_run_q <= '0;
        end else if (!active_i) begin
            chk_run_q <= '0;
        end else if (chk_run_q != CHK_W'(QUAL_CYCLES)) begin
            chk_run_q <= chk_run_q + 1'b1;
        end
    end

    assert_rise_after_full_run_R1: assert property (@(posedge clk_i) disable iff (!locked_i)
        $rose(qual_o) |-> (chk_run_q == CHK_W'(QUAL_CYCLES)));

    assert_hold_while_active_R5: assert property (@(posedge clk_i) disable iff (!locked_i)
        (qual_o && active_i) |=> qual_o);

    assert_drop_when_inactive_R6: assert property (@(posedge clk_i) disable iff (!locked_i)
        !active_i |=> !qual_o);

    initial begin
        assert (QUAL_CYCLES >= 1) else $error("qualification window must be at least one cycle");
    end

endmodule

// File: rtl/flt_rst_hold.sv
// Module: flt_rst_hold
// Output register. It forces the reset high while the clock is not locked
// and otherwise follows the qualified request one edge later. Because of
// this register, the reset that leaves the block changes only on clock edges.
// Assumes: locked_i low is the synchronous active-low reset of this stage.
module flt_rst_hold (
    input  logic clk_i,
    input  logic locked_i,
    input  logic qual_i,
    output logic rst_o
);

    logic rst_q;

    // Register the outgoing reset; assert it while lock is missing.
    always_ff @(posedge clk_i) begin
        if (!locked_i) begin
            rst_q <= 1'b1;
        end else begin
            rst_q <= qual_i;
        end
    end

    assign rst_o = rst_q;

    assert_lock_forces_reset_R7: assert property (@(posedge clk_i) disable iff (!locked_i)
        $rose(locked_i) |-> rst_o);

    assert_release_after_lock_R8: assert property (@(posedge clk_i) disable iff (!locked_i)
        $rose(locked_i) |=> !rst_o);

    assert_follow_qual_R2: assert property (@(posedge clk_i) disable iff (!locked_i)
        (locked_i && $past(locked_i)) |-> (rst_o == $past(qual_i)));

endmodule

// File: rtl/flt_rst_gen.sv
// Module: flt_rst_gen (top)
// Filtered synchronous reset generator for one clock domain. The path is:
// pin -> synchronizer chain -> qualification filter -> output register.
// Place one instance in every clock domain.
// Assumes: clk_locked_i is already synchronous to clk_i (tie it high when
// the domain has no PLL), SYNC_STAGES >= 2 and QUAL_CYCLES >= 1.
module flt_rst_gen
    import flt_rst_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned QUAL_CYCLES = 4,
    parameter filt_kind_e  FILT_KIND   = FILT_RUN_COUNT
) (
    input  logic clk_i,
    input  logic clk_locked_i,
    input  logic pin_rst_n_i,
    output logic rst_o
);

    logic sync_active;
    logic qual;

    flt_rst_sync_chain #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk_i       (clk_i),
        .pin_rst_n_i (pin_rst_n_i),
        .active_o    (sync_active)
    );

    flt_rst_qualifier #(
        .QUAL_CYCLES (QUAL_CYCLES),
        .KIND        (FILT_KIND)
    ) qual_i (
        .clk_i    (clk_i),
        .locked_i (clk_locked_i),
        .active_i (sync_active),
        .qual_o   (qual)
    );

    flt_rst_hold hold_i (
        .clk_i    (clk_i),
        .locked_i (clk_locked_i),
        .qual_i   (qual),
        .rst_o    (rst_o)
    );

endmodule

// File: tb/flt_rst_gen_tb_top.sv
// Directed bench for flt_rst_gen with the default parameters.
module flt_rst_gen_tb_top;

    localparam int SYNC = 2;
    localparam int NQ   = 4;

    logic clk = 1'b0;
    logic locked = 1'b0;
    logic pin_n = 1'b1;
    logic rst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flt_rst_gen #(
        .SYNC_STAGES (SYNC),
        .QUAL_CYCLES (NQ)
    ) dut_i (
        .clk_i        (clk),
        .clk_locked_i (locked),
        .pin_rst_n_i  (pin_n),
        .rst_o        (rst)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Lock low forces the reset; lock rising releases it on the next edge.
    task automatic t_lock_reset();
        locked = 1'b0;
        pin_n  = 1'b1;
        repeat (4) @(negedge clk);
        chk(rst == 1'b1, "R7 reset state", int'(rst), 1);
        locked = 1'b1;
        @(negedge clk);
        chk(rst == 1'b0, "R8 release after lock", int'(rst), 0);
        repeat (6) @(negedge clk);
        chk(rst == 1'b0, "R8 idle after lock", int'(rst), 0);
    endtask

    // Low pulse covering p edges; measure the reset pulses that follow.
    task automatic t_pulse(input int p, input string req);
        int rises = 0;
        int highs = 0;
        int first = 0;
        int last = 0;
        bit prev = 1'b0;
        pin_n = 1'b0;
        for (int i = 1; i <= p + NQ + 12; i++) begin
            @(negedge clk);
            if (i == p) begin
                pin_n = 1'b1;
                #1;
                chk(rst == prev, "R2 no mid-cycle change", int'(rst), int'(prev));
            end
            if (rst && !prev) rises++;
            if (rst) begin
                highs++;
                if (first == 0) first = i;
                last = i;
            end
            prev = rst;
        end
        if (p >= NQ) begin
            chk(rises == 1, {req, " R4 one pulse"}, rises, 1);
            chk(highs == p - NQ + 1, {req, " R4/R5 width"}, highs, p - NQ + 1);
            chk(first == SYNC + NQ + 1, {req, " R1 assert edge"}, first, SYNC + NQ + 1);
            chk(last + 1 == p + 1 + SYNC + 1, {req, " R6 release edge"}, last + 1, p + SYNC + 2);
        end else begin
            chk(rises == 0, {req, " R3 rejected"}, rises, 0);
            chk(highs == 0, {req, " R3 no high"}, highs, 0);
        end
    endtask

    // Glitch that covers no rising edge.
    task automatic t_glitch();
        int highs = 0;
        @(negedge clk);
        pin_n = 1'b0;
        #1;
        pin_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (rst) highs++;
        end
        chk(highs == 0, "R3 glitch rejected", highs, 0);
    endtask

    // Two short runs broken by one inactive edge.
    task automatic t_broken_run();
        int highs = 0;
        pin_n = 1'b0;
        for (int i = 1; i <= 2 * (NQ - 1) + 1 + 12; i++) begin
            @(negedge clk);
            if (i == NQ - 1) pin_n = 1'b1;
            if (i == NQ) pin_n = 1'b0;
            if (i == 2 * (NQ - 1) + 1) pin_n = 1'b1;
            if (rst) highs++;
        end
        chk(highs == 0, "R9 broken run rejected", highs, 0);
    endtask

    // Lock drops while running: reset held regardless of pin, then released.
    task automatic t_lock_hold();
        int lows = 0;
        @(negedge clk);
        locked = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            pin_n = i[0];
            if (!rst) lows++;
        end
        chk(lows == 0, "R7 held while unlocked", lows, 0);
        pin_n = 1'b1;
        repeat (3) @(negedge clk);
        locked = 1'b1;
        @(negedge clk);
        chk(rst == 1'b0, "R8 release after relock", int'(rst), 0);
    endtask

    initial begin
        t_lock_reset();
        t_pulse(1, "P1");
        t_pulse(NQ - 1, "Pn-1");
        t_pulse(NQ, "Pn");
        t_pulse(NQ + 1, "Pn+1");
        t_pulse(40, "P40");
        t_glitch();
        t_broken_run();
        t_lock_hold();
        t_pulse(NQ, "Pn after relock");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule